// File: doc/BRIEF.md
# Clock mode and wake-up controller

This block selects the clock that drives a small DSP core and handles deep sleep. It holds a 16-bit control word written over a simple write port. Three stop/select bits in that word pick a power mode. The mode is crystal, PLL, external clock, or sleep. In PLL mode a 2-bit select picks the VCO rate, half of it, a quarter of it, or twice the crystal rate. Every clock is modelled as a one-cycle enable pulse on a fast, always-running reference clock `clk`.

The crystal is a counter that produces one tick every `XTAL_CYC` reference cycles. The VCO is a phase accumulator that produces 4 × divisor ticks per crystal period. While asleep, the block watches up to three wake pins through synchronizers. When a selected pin makes a transition to the programmed level, the block leaves sleep and restores the low control fields to their defaults. It then holds the core in reset for a fixed number of core clock pulses, as it does after power-on.

Top module: `clkwake_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x0100 (divisor 1, everything else 0) and `asleep` is 0. `core_ce` gives one pulse per crystal period, and `core_rst` stays high for exactly `RST_CYC` (4) `core_ce` pulses and then falls.
- R2: A written divisor (bits 15:8) below 1 is stored as 1, and one above 156 is stored as 156. Values in range are stored unchanged.
- R3: Bits 2:0 hold {bypass, VCO stop, oscillator stop}. When bit 2 is 0 and bit 0 is 0, `core_ce` pulses once per `XTAL_CYC` cycles (the crystal rate), whatever bit 1 holds.
- R4: When bits 2:0 are 100, the clock select in bits 4:3 chooses the core rate. 00 gives 4 × divisor pulses per crystal period, 01 gives half of that, and 10 gives a quarter of that.
- R5: When bits 2:0 are 100 and bits 4:3 are 11, `core_ce` pulses twice per crystal period.
- R6: When bit 2 is 0 and bit 0 is 1 (external-clock mode), `core_ce` repeats the `ext_tick` input.
- R7: When bit 2 is 1 and bit 0 or bit 1 is 1 (deep sleep), `asleep` is 1 and `core_ce` stays 0. Writes are ignored until a wake event.
- R8: While asleep, a wake event occurs when a selected pin changes to the level in bit 7 (1 = high). Bits 6:5 select the pins: 00 selects pin 0, 01 pin 1, 10 pin 2, and 11 any of the three. Unselected pins are ignored, and so is a transition away from the level. A pin that is already at the level when sleep begins does not wake the block.
- R9: On wake, bits 4:0 become 0 and bits 15:5 are kept. `asleep` falls, and `core_rst` goes high for exactly 4 `core_ce` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| ext_tick | input | 1 | External clock, as an enable pulse |
| wake_pins | input | 3 | Asynchronous wake inputs |
| rd_data | output | 16 | Current control word |
| core_ce | output | 1 | Core clock enable pulse |
| core_rst | output | 1 | Core reset, high during restart |
| asleep | output | 1 | Deep sleep indicator |

## Verification
The hardest case to bring about is a pin that already sits at the wake level when sleep begins. The bench must show that this pin does not wake the block, while a later fresh transition on the same pin does. To get there, the bench raises pin 0 long before it writes the sleep word. It then toggles an unselected pin and makes a transition away from the level, and only then gives the real edge. After the wake it counts the `core_ce` pulses that occur while `core_rst` is high, to confirm the restart length.

// File: rtl/clkwake_pkg.sv
`timescale 1ns/1ps
package clkwake_pkg;

  typedef struct packed {
    logic [7:0] div;
    logic       pol;
    logic [1:0] wsrc;
    logic [1:0] csel;
    logic       byp;
    logic       vco_stop;
    logic       osc_stop;
  } clk_ctl_t;

  typedef enum logic [1:0] {SRC_XTAL, SRC_PLL, SRC_EXT, SRC_OFF} clk_src_e;

  function automatic clk_src_e pick_src(input clk_ctl_t c);
    if (c.byp) return (c.osc_stop || c.vco_stop) ? SRC_OFF : SRC_PLL;
    return c.osc_stop ? SRC_EXT : SRC_XTAL;
  endfunction

endpackage

// File: rtl/cw_ctrl_reg.sv
`timescale 1ns/1ps
module cw_ctrl_reg
  import clkwake_pkg::*;
#(
  parameter int DIV_MIN = 1,
  parameter int DIV_MAX = 156
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  input  logic        wake_hit,
  input  logic        locked,
  output clk_ctl_t    ctl
);
  localparam logic [7:0] DMIN = 8'(DIV_MIN);
  localparam logic [7:0] DMAX = 8'(DIV_MAX);
  localparam clk_ctl_t CTL_RST = '{div: DMIN, pol: 1'b0, wsrc: 2'b00,
                                   csel: 2'b00, byp: 1'b0, vco_stop: 1'b0,
                                   osc_stop: 1'b0};

  clk_ctl_t ctl_q, ctl_d;
  logic [7:0] wdiv;

  always_comb begin
    wdiv  = wr_data[15:8];
    ctl_d = ctl_q;
    if (wake_hit) begin
      ctl_d.csel     = 2'b00;
      ctl_d.byp      = 1'b0;
      ctl_d.vco_stop = 1'b0;
      ctl_d.osc_stop = 1'b0;
    end else if (wr_en && !locked) begin
      ctl_d = clk_ctl_t'(wr_data);
      if (wdiv < DMIN)      ctl_d.div = DMIN;
      else if (wdiv > DMAX) ctl_d.div = DMAX;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_RST;
    else        ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/cw_rate_gen.sv
`timescale 1ns/1ps
module cw_rate_gen
  import clkwake_pkg::*;
#(
  parameter int XTAL_CYC = 1024
) (
  input  logic     clk,
  input  logic     rst_n,
  input  clk_ctl_t ctl,
  input  logic     ext_tick,
  output logic     core_ce
);
  localparam int XW = $clog2(XTAL_CYC);
  localparam int AW = $clog2(XTAL_CYC + 1024) + 1;
  localparam logic [XW-1:0] X_LAST = XW'(XTAL_CYC - 1);
  localparam logic [XW-1:0] X_HALF = XW'(XTAL_CYC / 2 - 1);
  localparam logic [AW-1:0] A_WRAP = AW'(XTAL_CYC);

  logic [XW-1:0] xcnt_q, xcnt_d;
  logic [AW-1:0] acc_q, acc_d, acc_sum;
  logic [1:0]    dcnt_q, dcnt_d;
  logic osc_run, vco_run, xtal_tick, x2_tick, vco_tick;
  clk_src_e src;

  always_comb begin
    osc_run   = !ctl.osc_stop;
    vco_run   = osc_run && !ctl.vco_stop;
    xtal_tick = osc_run && (xcnt_q == X_LAST);
    x2_tick   = osc_run && ((xcnt_q == X_LAST) || (xcnt_q == X_HALF));
    acc_sum   = acc_q + AW'({ctl.div, 2'b00});
    vco_tick  = vco_run && (acc_sum >= A_WRAP);

    xcnt_d = xcnt_q;
    if (osc_run) xcnt_d = (xcnt_q == X_LAST) ? '0 : xcnt_q + 1'b1;
    acc_d = acc_q;
    if (vco_run) acc_d = vco_tick ? acc_sum - A_WRAP : acc_sum;
    dcnt_d = vco_tick ? dcnt_q + 2'd1 : dcnt_q;

    src = pick_src(ctl);
    unique case (src)
      SRC_XTAL: core_ce = xtal_tick;
      SRC_EXT:  core_ce = ext_tick;
      SRC_PLL: begin
        unique case (ctl.csel)
          2'b00:   core_ce = vco_tick;
          2'b01:   core_ce = vco_tick && dcnt_q[0];
          2'b10:   core_ce = vco_tick && (&dcnt_q);
          default: core_ce = x2_tick;
        endcase
      end
      default:  core_ce = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xcnt_q <= '0;
      acc_q  <= '0;
      dcnt_q <= '0;
    end else begin
      xcnt_q <= xcnt_d;
      acc_q  <= acc_d;
      dcnt_q <= dcnt_d;
    end
  end
endmodule

// File: rtl/cw_wake_det.sv
`timescale 1ns/1ps
module cw_wake_det #(
  parameter int NPIN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins,
  input  logic            pol,
  input  logic [1:0]      wsrc,
  input  logic            armed,
  output logic            wake_hit
);
  logic [NPIN-1:0] hit_vec, mask;

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [2:0] sh_q, sh_d;
    always_comb sh_d = {sh_q[1:0], pins[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_d;
    end
    assign hit_vec[g] = (sh_q[1] == pol) && (sh_q[2] != pol);
  end

  always_comb begin
    mask     = (wsrc == 2'b11) ? '1 : (NPIN'(1) << wsrc);
    wake_hit = armed && |(hit_vec & mask);
  end
endmodule

// File: rtl/clkwake_ctrl.sv
`timescale 1ns/1ps
module clkwake_ctrl
  import clkwake_pkg::*;
#(
  parameter int XTAL_CYC = 1024,
  parameter int DIV_MIN  = 1,
  parameter int DIV_MAX  = 156,
  parameter int RST_CYC  = 4,
  parameter int NPIN     = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [15:0]     wr_data,
  input  logic            ext_tick,
  input  logic [NPIN-1:0] wake_pins,
  output logic [15:0]     rd_data,
  output logic            core_ce,
  output logic            core_rst,
  output logic            asleep
);
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [RW-1:0] R_DONE = RW'(RST_CYC);

  clk_ctl_t ctl;
  logic wake_hit;
  logic [RW-1:0] rcnt_q, rcnt_d;

  assign asleep = (pick_src(ctl) == SRC_OFF);

  cw_ctrl_reg #(.DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wake_hit(wake_hit), .locked(asleep), .ctl(ctl));

  cw_rate_gen #(.XTAL_CYC(XTAL_CYC)) u_rate (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .ext_tick(ext_tick),
    .core_ce(core_ce));

  cw_wake_det #(.NPIN(NPIN)) u_wake (
    .clk(clk), .rst_n(rst_n), .pins(wake_pins), .pol(ctl.pol),
    .wsrc(ctl.wsrc), .armed(asleep), .wake_hit(wake_hit));

  always_comb begin
    core_rst = (rcnt_q != R_DONE);
    rcnt_d   = rcnt_q;
    if (wake_hit)                  rcnt_d = '0;
    else if (core_rst && core_ce)  rcnt_d = rcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcnt_q <= '0;
    else        rcnt_q <= rcnt_d;
  end

  assign rd_data = ctl;
endmodule

// File: rtl/clkwake_ctrl_chk.sv
`timescale 1ns/1ps
module clkwake_ctrl_chk #(
  parameter int DIV_MIN = 1,
  parameter int DIV_MAX = 156
) (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] rd_data,
  input logic        core_ce,
  input logic        core_rst,
  input logic        asleep
);
  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[15:8] >= 8'(DIV_MIN)) && (rd_data[15:8] <= 8'(DIV_MAX)));

  // R7
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !core_ce);

  // R9
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (rd_data[4:0] == 5'd0) && core_rst);

  // R9
  wake_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> rd_data[15:5] == $past(rd_data[15:5]));

  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> $past(core_ce));
endmodule

bind clkwake_ctrl clkwake_ctrl_chk #(.DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .core_ce(core_ce),
  .core_rst(core_rst), .asleep(asleep));

// File: tb/clkwake_ctrl_bench.sv
`timescale 1ns/1ps
module clkwake_ctrl_bench;
  localparam int W = 4096;
  localparam int NV = 9;

  logic clk, rst_n, wr_en, ext_tick;
  logic [15:0] wr_data, rd_data;
  logic [2:0] wake_pins;
  logic core_ce, core_rst, asleep;
  int errors, checks, ext_cnt, cnt;
  bit done;

  typedef struct packed { logic [15:0] word; logic [31:0] exp; } vec_t;
  // R3 crystal, R4 PLL rates, R2 clamped/zero divisor, R5 twice crystal, R6 external
  localparam vec_t VECS [NV] = '{
    '{16'h0100, 32'd4},    '{16'h0104, 32'd16},  '{16'h0A0C, 32'd80},
    '{16'h9C14, 32'd624},  '{16'hC804, 32'd2496},'{16'h0004, 32'd16},
    '{16'h051C, 32'd8},    '{16'h0302, 32'd4},   '{16'h0103, 32'd1024}};

  clkwake_ctrl u_clkwake_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_tick(ext_tick), .wake_pins(wake_pins), .rd_data(rd_data),
    .core_ce(core_ce), .core_rst(core_rst), .asleep(asleep));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial ext_cnt = 0;
  always @(negedge clk) begin
    ext_cnt  <= ext_cnt + 1;
    ext_tick <= (ext_cnt % 4) == 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count_ce(input int n, output int c);
    c = 0;
    repeat (n) begin @(negedge clk); if (core_ce) c++; end
  endtask

  task automatic count_rst(output int c);
    int guard;
    c = 0; guard = 0;
    while (core_rst && guard < 20000) begin
      @(negedge clk); if (core_ce && core_rst) c++; guard++;
    end
  endtask

  initial begin
    errors = 0; checks = 0; done = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wake_pins = 3'b000;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == 16'h0100, "R1 reset word", rd_data, 16'h0100);
    check(asleep == 1'b0, "R1 awake", asleep, 0);
    check(core_rst == 1'b1, "R1 core reset high", core_rst, 1);
    count_rst(cnt);
    check(cnt == 4, "R1 reset length", cnt, 4);
    check(core_rst == 1'b0, "R1 reset released", core_rst, 0);

    write_reg(16'hC800);
    check(rd_data == 16'h9C00, "R2 clamp high", rd_data, 16'h9C00);
    write_reg(16'h0000);
    check(rd_data == 16'h0100, "R2 clamp zero", rd_data, 16'h0100);
    write_reg(16'h7F00);
    check(rd_data == 16'h7F00, "R2 in range", rd_data, 16'h7F00);

    for (int i = 0; i < NV; i++) begin
      write_reg(VECS[i].word);
      count_ce(W, cnt);
      check((cnt >= int'(VECS[i].exp) - 1) && (cnt <= int'(VECS[i].exp) + 1),
            $sformatf("R3/R4/R5/R6 rate word %h", VECS[i].word), cnt, int'(VECS[i].exp));
    end

    // R8 pin already at level before sleep
    wake_pins[0] = 1'b1;
    repeat (10) @(negedge clk);
    write_reg(16'h0187);
    repeat (5) @(negedge clk);
    check(asleep == 1'b1, "R7 enter sleep", asleep, 1);
    count_ce(3000, cnt);
    check(cnt == 0, "R7 no clock asleep", cnt, 0);
    write_reg(16'h0100);
    check(rd_data == 16'h0187, "R7 write ignored", rd_data, 16'h0187);
    repeat (20) @(negedge clk);
    check(asleep == 1'b1, "R8 level already present", asleep, 1);
    wake_pins[1] = 1'b1;
    repeat (20) @(negedge clk);
    check(asleep == 1'b1, "R8 unselected pin", asleep, 1);
    wake_pins[0] = 1'b0;
    repeat (20) @(negedge clk);
    check(asleep == 1'b1, "R8 edge away from level", asleep, 1);
    wake_pins[0] = 1'b1;
    repeat (10) @(negedge clk);
    check(asleep == 1'b0, "R8 wake on pin0 high", asleep, 0);
    check(rd_data == 16'h0180, "R9 restored word", rd_data, 16'h0180);
    check(core_rst == 1'b1, "R9 core reset on wake", core_rst, 1);
    count_rst(cnt);
    check(cnt == 4, "R9 restart length", cnt, 4);

    wake_pins = 3'b111;
    repeat (10) @(negedge clk);
    write_reg(16'h0A67);
    repeat (5) @(negedge clk);
    check(asleep == 1'b1, "R7 sleep any-pin", asleep, 1);
    wake_pins[2] = 1'b0;
    repeat (10) @(negedge clk);
    check(asleep == 1'b0, "R8 any-pin low wake", asleep, 0);
    check(rd_data == 16'h0A60, "R9 keep divisor and wake cfg", rd_data, 16'h0A60);

    write_reg(16'h0125);
    repeat (5) @(negedge clk);
    check(asleep == 1'b1, "R7 sleep via bypass+osc stop", asleep, 1);
    wake_pins[1] = 1'b0;
    repeat (10) @(negedge clk);
    check(asleep == 1'b0, "R8 pin1 low wake", asleep, 0);
    check(rd_data == 16'h0120, "R9 restored pin1 word", rd_data, 16'h0120);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule